// File: doc/BRIEF.md
# Dual-Target Passive Serial Loader

This block sits on the host side of a board that carries two programmable-logic targets. It loads a bitstream into either target, one at a time and in any order. Both targets share a single serial data line and a single serial clock. Each target has its own reset line (active-low configure request), status input, done input, init-complete input and active-low enable. Only the chosen target is ever enabled, so the unselected target ignores the shared clock and data.

A load begins with a one-cycle start strobe, a target index and a length in bits. The controller pulses the chosen target's configure line low and waits for its status line to come back high. It then enables the target and fetches 32-bit words from a ready/valid stream. Each word goes out least-significant bit first, one bit per rising edge of the serial clock. Any bit positions past the stated length are sent as zeros. After the data, a fixed number of extra clocks follows. The controller then checks the done input, releases the enable and waits for init-complete. At the end it pulses `done` with a result code.

The serial clock runs at a parameter-set fraction of the system clock. Data only changes while the serial clock is low.

Top module: `ps_cfg_master`

## Requirements
- R1: After reset, every configure line and every enable line is high, `dclk` is low, and `busy`, `done` and `wd_ready` are low.
- R2: After a start, the selected target's configure line is low for exactly PULSE_CYC system cycles. The other target's configure line stays high.
- R3: If the selected status line is still low ST_TO cycles after the pulse ends, the load ends with code 1. No enable goes low and no serial clock edge is produced.
- R4: At most one enable line is low at any time. The unselected target's enable never goes low during a load.
- R5: Word bit 0 is presented first. `data0` is sampled at each rising edge of `dclk` and changes only while `dclk` is low.
- R6: Exactly ceil(bit_len/32) words are taken from the stream. Every bit position at or beyond `bit_len` goes out as 0.
- R7: After the data bits, exactly TRAIL_CLKS further rising edges follow with `data0` at 0, with the target still enabled.
- R8: If the selected done input is low once the trailing clocks are finished, the load ends with code 2.
- R9: Once done is seen, the enable is released. If init-complete then rises within INIT_TO cycles the result code is 0; otherwise the code is 3.
- R10: If the selected status line falls while data is being shifted, the load stops, the enable is released and the code is 4.
- R11: `done` is a single-cycle pulse that coincides with the last cycle of `busy`. `err_code` holds its value until the next start.
- R12: A start strobe that arrives while a load is in progress has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a load |
| tgt_sel | input | $clog2(N_TGT) | Index of the target to load |
| bit_len | input | LEN_W | Bitstream length in bits |
| wd_data | input | 32 | Bitstream word, bit 0 sent first |
| wd_valid | input | 1 | Word stream valid |
| wd_ready | output | 1 | Word stream ready |
| cfg_n | output | N_TGT | Per-target active-low configure request |
| status_n | input | N_TGT | Per-target active-low status |
| conf_done | input | N_TGT | Per-target configuration done |
| init_done | input | N_TGT | Per-target initialization complete |
| ce_n | output | N_TGT | Per-target active-low enable |
| dclk | output | 1 | Shared serial clock |
| data0 | output | 1 | Shared serial data |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 3 | 0 ok, 1 status timeout, 2 done missing, 3 init timeout, 4 status lost |

## Verification
The assertions check on every cycle that at most one enable is low, that no enable is low while a configure line is low, that data holds steady while the serial clock is high, that the clock rests low when idle, and that the target selection does not change mid-load. Some behaviours only the bench scenarios can show: the bit order and zero padding of the serial stream, the exact word and trailing-clock counts, the length of the configure pulse, and the mapping of each failure (a stuck status line, a missing done, a missing init, status lost mid-shift) to its result code.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;

    localparam int WORD_W = 32;
    localparam int NB_W   = $clog2(WORD_W + 1);

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_PULSE,
        SQ_WAIT_ST,
        SQ_SHIFT,
        SQ_CHECK,
        SQ_WAIT_INIT,
        SQ_FINISH
    } seq_st_e;

    typedef enum logic [1:0] {
        SR_IDLE,
        SR_DATA,
        SR_TRAIL,
        SR_DONE
    } ser_st_e;

    typedef enum logic [2:0] {
        ERR_NONE        = 3'd0,
        ERR_STATUS_TO   = 3'd1,
        ERR_CONF_DONE   = 3'd2,
        ERR_INIT_TO     = 3'd3,
        ERR_STATUS_LOST = 3'd4
    } cfg_err_e;

    // Keep the low 'keep' bits of a word, clear the rest (tail padding).
    function automatic logic [WORD_W-1:0] pad_word(input logic [WORD_W-1:0] w,
                                                   input logic [NB_W-1:0]   keep);
        logic [WORD_W-1:0] r;
        for (int b = 0; b < WORD_W; b++) begin
            r[b] = (NB_W'(b) < keep) ? w[b] : 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/ps_sclk_gen.sv
module ps_sclk_gen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic sclk,
    output logic rise,
    output logic fall
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt;
    logic          term;

    assign term = run && (cnt == CW'(HALF_DIV - 1));
    assign rise = term && !sclk;
    assign fall = term && sclk;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (term) begin
            cnt  <= '0;
            sclk <= !sclk;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end

    // R5: clock parks low whenever shifting pauses
    a_r5_sclk_parks_low: assert property (@(posedge clk) disable iff (rst)
        !run |=> !sclk);

endmodule

// File: rtl/ps_bit_shifter.sv
module ps_bit_shifter
    import ps_cfg_pkg::*;
#(
    parameter int LEN_W      = 24,
    parameter int TRAIL_CLKS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              begin_i,
    input  logic              abort_i,
    input  logic [LEN_W-1:0]  bit_len_i,
    input  logic [WORD_W-1:0] wd_data_i,
    input  logic              wd_valid_i,
    output logic              wd_ready_o,
    input  logic              fall_i,
    output logic              run_o,
    output logic              bit_o,
    output logic              done_o
);
    localparam int LW1  = LEN_W + 1;
    localparam int TC_W = $clog2(TRAIL_CLKS + 1);

    ser_st_e           phase;
    logic [WORD_W-1:0] sh;
    logic [NB_W-1:0]   nbits;
    logic [LEN_W-1:0]  words_left;
    logic [LEN_W-1:0]  data_left;
    logic [TC_W-1:0]   trail_left;
    logic [NB_W-1:0]   keep;
    logic [LEN_W-1:0]  words_calc;
    logic              take;

    assign words_calc = LEN_W'((LW1'(bit_len_i) + LW1'(WORD_W - 1)) >> $clog2(WORD_W));
    assign keep       = (data_left >= LEN_W'(WORD_W)) ? NB_W'(WORD_W) : NB_W'(data_left);
    assign wd_ready_o = (phase == SR_DATA) && (nbits == '0) && (words_left != '0);
    assign take       = wd_ready_o && wd_valid_i;
    assign run_o      = ((phase == SR_DATA) && (nbits != '0)) || (phase == SR_TRAIL);
    assign bit_o      = sh[0];
    assign done_o     = (phase == SR_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= SR_IDLE;
            sh         <= '0;
            nbits      <= '0;
            words_left <= '0;
            data_left  <= '0;
            trail_left <= '0;
        end else if (abort_i) begin
            phase <= SR_IDLE;
            nbits <= '0;
        end else begin
            unique case (phase)
                SR_IDLE, SR_DONE: begin
                    if (begin_i) begin
                        phase      <= SR_DATA;
                        sh         <= '0;
                        nbits      <= '0;
                        words_left <= words_calc;
                        data_left  <= bit_len_i;
                        trail_left <= TC_W'(TRAIL_CLKS);
                    end
                end
                SR_DATA: begin
                    if (take) begin
                        sh         <= pad_word(wd_data_i, keep);
                        nbits      <= NB_W'(WORD_W);
                        words_left <= words_left - 1'b1;
                        data_left  <= data_left - LEN_W'(keep);
                    end else if (fall_i && nbits != '0) begin
                        sh    <= sh >> 1;
                        nbits <= nbits - 1'b1;
                        if (nbits == NB_W'(1) && words_left == '0) phase <= SR_TRAIL;
                    end else if (nbits == '0 && words_left == '0) begin
                        phase <= SR_TRAIL;
                    end
                end
                SR_TRAIL: begin
                    if (fall_i) begin
                        trail_left <= trail_left - 1'b1;
                        if (trail_left == TC_W'(1)) phase <= SR_DONE;
                    end
                end
                default: phase <= SR_IDLE;
            endcase
        end
    end

    // R6: a word register never holds more than one word of bits
    a_r6_nbits_bound: assert property (@(posedge clk) disable iff (rst)
        nbits <= NB_W'(WORD_W));
    // R6: a fetched word always arrives full
    a_r6_full_after_take: assert property (@(posedge clk) disable iff (rst)
        (take && !abort_i) |=> (nbits == NB_W'(WORD_W)));
    // R7: the trailing phase always has clocks left to send
    a_r7_trail_nonzero: assert property (@(posedge clk) disable iff (rst)
        (phase == SR_TRAIL) |-> (trail_left != '0));

endmodule

// File: rtl/ps_cfg_seq.sv
module ps_cfg_seq
    import ps_cfg_pkg::*;
#(
    parameter int N_TGT     = 2,
    parameter int PULSE_CYC = 8,
    parameter int ST_TO     = 1000,
    parameter int INIT_TO   = 1000
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              start_i,
    input  logic [((N_TGT>1)?$clog2(N_TGT):1)-1:0] sel_i,
    input  logic [N_TGT-1:0]                  status_n_i,
    input  logic [N_TGT-1:0]                  conf_done_i,
    input  logic [N_TGT-1:0]                  init_done_i,
    input  logic                              ser_done_i,
    output logic                              ser_begin_o,
    output logic                              ser_abort_o,
    output logic [N_TGT-1:0]                  cfg_n_o,
    output logic [N_TGT-1:0]                  ce_n_o,
    output logic                              busy_o,
    output logic                              done_o,
    output logic [2:0]                        err_o
);
    localparam int SW    = (N_TGT > 1) ? $clog2(N_TGT) : 1;
    localparam int TMAX0 = (PULSE_CYC > ST_TO) ? PULSE_CYC : ST_TO;
    localparam int TMAX  = (TMAX0 > INIT_TO) ? TMAX0 : INIT_TO;
    localparam int TW    = $clog2(TMAX + 1);

    seq_st_e       state;
    logic [SW-1:0] sel;
    logic [TW-1:0] timer;
    cfg_err_e      err_q;
    logic          st_ok;

    assign st_ok       = status_n_i[sel];
    assign ser_begin_o = (state == SQ_WAIT_ST) && st_ok;
    assign ser_abort_o = (state == SQ_SHIFT) && !st_ok;
    assign busy_o      = (state != SQ_IDLE);
    assign done_o      = (state == SQ_FINISH);
    assign err_o       = err_q;

    for (genvar g = 0; g < N_TGT; g++) begin : g_tgt
        assign cfg_n_o[g] = !((state == SQ_PULSE) && (sel == SW'(g)));
        assign ce_n_o[g]  = !(((state == SQ_SHIFT) || (state == SQ_CHECK)) && (sel == SW'(g)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            sel   <= '0;
            timer <= '0;
            err_q <= ERR_NONE;
        end else begin
            unique case (state)
                SQ_IDLE: begin
                    if (start_i) begin
                        sel   <= sel_i;
                        timer <= '0;
                        err_q <= ERR_NONE;
                        state <= SQ_PULSE;
                    end
                end
                SQ_PULSE: begin
                    if (timer == TW'(PULSE_CYC - 1)) begin
                        timer <= '0;
                        state <= SQ_WAIT_ST;
                    end else begin
                        timer <= timer + 1'b1;
                    end
                end
                SQ_WAIT_ST: begin
                    if (st_ok) begin
                        state <= SQ_SHIFT;
                    end else if (timer == TW'(ST_TO - 1)) begin
                        err_q <= ERR_STATUS_TO;
                        state <= SQ_FINISH;
                    end else begin
                        timer <= timer + 1'b1;
                    end
                end
                SQ_SHIFT: begin
                    if (!st_ok) begin
                        err_q <= ERR_STATUS_LOST;
                        state <= SQ_FINISH;
                    end else if (ser_done_i) begin
                        state <= SQ_CHECK;
                    end
                end
                SQ_CHECK: begin
                    timer <= '0;
                    if (conf_done_i[sel]) begin
                        state <= SQ_WAIT_INIT;
                    end else begin
                        err_q <= ERR_CONF_DONE;
                        state <= SQ_FINISH;
                    end
                end
                SQ_WAIT_INIT: begin
                    if (init_done_i[sel]) begin
                        state <= SQ_FINISH;
                    end else if (timer == TW'(INIT_TO - 1)) begin
                        err_q <= ERR_INIT_TO;
                        state <= SQ_FINISH;
                    end else begin
                        timer <= timer + 1'b1;
                    end
                end
                SQ_FINISH: state <= SQ_IDLE;
                default:   state <= SQ_IDLE;
            endcase
        end
    end

    // R4: never more than one target enabled
    a_r4_one_enable: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~ce_n_o));
    // R2: no target enabled while any configure line is held low
    a_r2_pulse_no_enable: assert property (@(posedge clk) disable iff (rst)
        !(&cfg_n_o) |-> (&ce_n_o));
    // R11: completion strobe lasts a single cycle and ends the load
    a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (!done_o && !busy_o));
    // R12: selection is frozen while a load runs
    a_r12_sel_frozen: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> $stable(sel));
    // R3: wait counters stay inside their window
    a_r3_timer_bound: assert property (@(posedge clk) disable iff (rst)
        timer < TW'(TMAX));

endmodule

// File: rtl/ps_cfg_master.sv
module ps_cfg_master
    import ps_cfg_pkg::*;
#(
    parameter int N_TGT      = 2,
    parameter int LEN_W      = 24,
    parameter int HALF_DIV   = 2,
    parameter int PULSE_CYC  = 8,
    parameter int ST_TO      = 1000,
    parameter int INIT_TO    = 1000,
    parameter int TRAIL_CLKS = 8,
    localparam int SW        = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [SW-1:0]     tgt_sel,
    input  logic [LEN_W-1:0]  bit_len,
    input  logic [WORD_W-1:0] wd_data,
    input  logic              wd_valid,
    output logic              wd_ready,
    output logic [N_TGT-1:0]  cfg_n,
    input  logic [N_TGT-1:0]  status_n,
    input  logic [N_TGT-1:0]  conf_done,
    input  logic [N_TGT-1:0]  init_done,
    output logic [N_TGT-1:0]  ce_n,
    output logic              dclk,
    output logic              data0,
    output logic              busy,
    output logic              done,
    output logic [2:0]        err_code
);
    logic ser_begin, ser_abort, ser_done, ser_run, clk_rise, clk_fall;

    ps_cfg_seq #(
        .N_TGT(N_TGT), .PULSE_CYC(PULSE_CYC), .ST_TO(ST_TO), .INIT_TO(INIT_TO)
    ) u_seq (
        .clk(clk), .rst(rst), .start_i(start), .sel_i(tgt_sel),
        .status_n_i(status_n), .conf_done_i(conf_done), .init_done_i(init_done),
        .ser_done_i(ser_done), .ser_begin_o(ser_begin), .ser_abort_o(ser_abort),
        .cfg_n_o(cfg_n), .ce_n_o(ce_n), .busy_o(busy), .done_o(done), .err_o(err_code)
    );

    ps_bit_shifter #(.LEN_W(LEN_W), .TRAIL_CLKS(TRAIL_CLKS)) u_shift (
        .clk(clk), .rst(rst), .begin_i(ser_begin), .abort_i(ser_abort),
        .bit_len_i(bit_len), .wd_data_i(wd_data), .wd_valid_i(wd_valid),
        .wd_ready_o(wd_ready), .fall_i(clk_fall), .run_o(ser_run),
        .bit_o(data0), .done_o(ser_done)
    );

    ps_sclk_gen #(.HALF_DIV(HALF_DIV)) u_clk (
        .clk(clk), .rst(rst), .run(ser_run), .sclk(dclk),
        .rise(clk_rise), .fall(clk_fall)
    );

    // R5: serial data holds while the serial clock is high
    a_r5_data_steady: assert property (@(posedge clk) disable iff (rst)
        dclk |-> $stable(data0));
    // R5: a rising edge is never generated with the shifter stopped
    a_r5_rise_needs_run: assert property (@(posedge clk) disable iff (rst)
        clk_rise |-> ser_run);
    // R3: the serial clock stays low whenever no target is enabled and nothing runs
    a_r3_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(!busy)) |-> !dclk);

endmodule

// File: tb/ps_cfg_master_test.sv
module ps_cfg_master_test;
    localparam int HALF_DIV = 2, PULSE = 4, ST_TO = 20, INIT_TO = 30, TRAIL = 8, LEN_W = 16;
    localparam int M_OK = 0, M_STUCK = 1, M_NOCD = 2, M_NOINIT = 3, M_DROP = 4;

    // {target, length, model mode, expected code}
    localparam logic [22:0] VECS [0:7] = '{
        {1'b0, 16'd40, 3'd0, 3'd0},
        {1'b1, 16'd64, 3'd0, 3'd0},
        {1'b0, 16'd1,  3'd0, 3'd0},
        {1'b1, 16'd95, 3'd0, 3'd0},
        {1'b0, 16'd48, 3'd1, 3'd1},
        {1'b1, 16'd48, 3'd2, 3'd2},
        {1'b0, 16'd48, 3'd3, 3'd3},
        {1'b1, 16'd96, 3'd4, 3'd4}
    };

    logic clk = 0, rst = 1, start = 0, tgt_sel = 0, wd_valid = 0;
    logic [LEN_W-1:0] bit_len = '0;
    logic [31:0] wd_data = '0;
    logic wd_ready, dclk, data0, busy, done;
    logic [1:0] cfg_n, ce_n;
    logic [1:0] status_n = 2'b11, conf_done = 2'b00, init_done = 2'b00;
    logic [2:0] err_code;

    int checks = 0, fails = 0;
    int cur_tgt = 0, cur_len = 0, mode = 0;
    int widx = 0, rises = 0, bit_err = 0, done_hi = 0, st_cnt = 3, ini_cnt = 0;
    int cfgl [2];
    bit ce_seen [2];
    bit hs = 0, prev_dclk = 0, prev_data = 0, finished = 0;

    always #4 clk = ~clk;

    ps_cfg_master #(.N_TGT(2), .LEN_W(LEN_W), .HALF_DIV(HALF_DIV), .PULSE_CYC(PULSE),
                    .ST_TO(ST_TO), .INIT_TO(INIT_TO), .TRAIL_CLKS(TRAIL)) uut (
        .clk(clk), .rst(rst), .start(start), .tgt_sel(tgt_sel), .bit_len(bit_len),
        .wd_data(wd_data), .wd_valid(wd_valid), .wd_ready(wd_ready), .cfg_n(cfg_n),
        .status_n(status_n), .conf_done(conf_done), .init_done(init_done), .ce_n(ce_n),
        .dclk(dclk), .data0(data0), .busy(busy), .done(done), .err_code(err_code));

    function automatic logic [31:0] gen(input int i);
        return 32'h1357_9BDF ^ (32'(i) * 32'h9E37_79B9);
    endfunction

    function automatic logic expbit(input int k);
        int nw;
        logic [31:0] w;
        nw = (cur_len + 31) / 32;
        if (k >= nw * 32 || k >= cur_len) return 1'b0;
        w = gen(k / 32);
        return w[k % 32];
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) hs <= wd_valid && wd_ready;

    // Target model and monitors, evaluated away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            if (hs) begin
                widx++;
                wd_data = gen(widx);
            end
            if (dclk && prev_dclk && data0 != prev_data) bit_err++;
            if (dclk && !prev_dclk && !ce_n[cur_tgt]) begin
                if (data0 != expbit(rises)) bit_err++;
                rises++;
            end
            prev_dclk = dclk;
            prev_data = data0;
            for (int i = 0; i < 2; i++) begin
                if (!cfg_n[i]) cfgl[i]++;
                if (!ce_n[i]) ce_seen[i] = 1;
            end
            if (done) done_hi++;
            if (!cfg_n[cur_tgt]) begin
                status_n[cur_tgt] = 0;
                st_cnt = 0;
                ini_cnt = 0;
                conf_done[cur_tgt] = 0;
                init_done[cur_tgt] = 0;
            end else begin
                if (mode != M_STUCK && st_cnt < 3) begin
                    st_cnt++;
                    if (st_cnt == 3) status_n[cur_tgt] = 1;
                end
                if (mode == M_DROP && rises >= 20) status_n[cur_tgt] = 0;
                conf_done[cur_tgt] = (mode != M_NOCD) && (rises >= cur_len) && (st_cnt == 3);
                if (conf_done[cur_tgt] && ce_n[cur_tgt] && mode != M_NOINIT) begin
                    ini_cnt++;
                    if (ini_cnt >= 5) init_done[cur_tgt] = 1;
                end
            end
            status_n[1 - cur_tgt]  = 1;
            conf_done[1 - cur_tgt] = 0;
            init_done[1 - cur_tgt] = 0;
        end
    end

    task automatic run_vec(input int t, input int len, input int m, input int exp, input bit poke);
        int nw, oth, guard;
        @(negedge clk);
        cur_tgt = t; cur_len = len; mode = m; oth = 1 - t;
        widx = 0; rises = 0; bit_err = 0; done_hi = 0; st_cnt = 3; ini_cnt = 0;
        cfgl[0] = 0; cfgl[1] = 0; ce_seen[0] = 0; ce_seen[1] = 0;
        status_n = 2'b11; conf_done = 2'b00; init_done = 2'b00;
        wd_data = gen(0); wd_valid = 1;
        tgt_sel = t[0]; bit_len = LEN_W'(len); start = 1;
        @(negedge clk);
        start = 0;
        if (poke) begin
            repeat (2) @(negedge clk);
            tgt_sel = oth[0]; start = 1;           // R12: start while busy
            @(negedge clk);
            start = 0;
        end
        guard = 0;
        while (!done && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);
        wd_valid = 0;
        nw = (len + 31) / 32;
        check(err_code == 3'(exp), "R8 R9 R3 R10 result code", int'(err_code), exp);
        check(cfgl[t] == PULSE, "R2 pulse width", cfgl[t], PULSE);
        check(cfgl[oth] == 0 && !ce_seen[oth], "R4 R12 other target untouched", cfgl[oth], 0);
        check(done_hi == 1 && !busy, "R11 single done pulse", done_hi, 1);
        check(bit_err == 0, "R5 bit order and data hold", bit_err, 0);
        if (exp == 0 || exp == 2) begin
            check(widx == nw, "R6 words fetched", widx, nw);
            check(rises == nw * 32 + TRAIL, "R7 total rising edges", rises, nw * 32 + TRAIL);
        end
        if (exp == 1) check(rises == 0 && !ce_seen[t], "R3 no shift on timeout", rises, 0);
        if (exp == 4 || exp == 3) check(ce_n[t] == 1'b1, "R10 R9 enable released", int'(ce_n[t]), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(cfg_n == 2'b11 && ce_n == 2'b11, "R1 reset lines high", int'({cfg_n, ce_n}), 15);
        check(!dclk && !busy && !done && !wd_ready, "R1 reset quiet", int'({dclk, busy, done, wd_ready}), 0);
        rst = 0;
        @(negedge clk);
        check(cfg_n == 2'b11 && !busy, "R1 idle after reset", int'(cfg_n), 3);
        for (int v = 0; v < 8; v++) begin
            run_vec(int'(VECS[v][22]), int'(VECS[v][21:6]), int'(VECS[v][5:3]), int'(VECS[v][2:0]), 1'b0);
        end
        run_vec(0, 40, M_OK, 0, 1'b1);          // R12 directed
        run_vec(1, 32, M_OK, 0, 1'b0);          // R6 exact single word
        run_vec(0, 33, M_OK, 0, 1'b0);          // R6 one bit into a second word
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule